// File: doc/BRIEF.md
# Multi-Mode Quadrature Decoder Front End

This block sits between two raw encoder channels, A and B, and a downstream position counter. Both channels pass through a two-flop synchronizer and a sampled glitch filter. A filter tick, divided down from the system clock, paces the filter. The filtered pair then goes to edge logic that produces one count per qualified transition, according to the selected resolution. The block has four input interpretations:

- plain clock/direction, where A is the count clock and B is the direction level;
- single resolution (one count per quadrature cycle);
- double resolution (two counts per quadrature cycle);
- quadruple resolution (four counts per quadrature cycle).

A divide select halves the filter tick rate. This trades maximum count rate for better noise rejection.

The count strobe works as a valid with no ready. It is high for exactly one system clock per count, and `dir_up_o` qualifies it in the same cycle. The downstream counter has no way to stall the block, so it must accept every strobe in the cycle it appears. The strobe stays low while `cnt_en_i` is low. `dir_state_o` holds the most recently decoded direction, and it keeps tracking whether counting is enabled or not.

Top module: `qdec_front`

## Requirements
- R1: After reset, `step_o` is 0, and both `dir_up_o` and `dir_state_o` are 1 (up).
- R2: With `mode_i` = 2'b00, each filtered rising edge of A gives one count, and the direction is the filtered level of B (1 = up). Falling edges of A and any change on B give no count.
- R3: With `mode_i` = 2'b11, every legal single-channel transition gives one count, which is four counts per full quadrature cycle.
- R4: With `mode_i` = 2'b10, counts come from both edges of A only, which is two counts per full quadrature cycle.
- R5: With `mode_i` = 2'b01, a count comes only from a rising A edge while moving up, or from a falling A edge while moving down. This is one count per full quadrature cycle.
- R6: With the pair written as {B,A}, the order 00→01→11→10→00 is up and the reverse order is down. In the quadrature modes, `dir_state_o` takes the direction of each legal transition.
- R7: A filtered input changes only when the synchronized value is identical on two consecutive filter ticks. A pulse that spans fewer than two ticks is discarded.
- R8: With `filt_div2_i` = 0, a filter tick occurs every BASE_DIV clocks. With `filt_div2_i` = 1, it occurs every 2*BASE_DIV clocks. At BASE_DIV = 4, an 8-clock pulse on A is accepted at divide 1 and discarded at divide 2.
- R9: In the quadrature modes, a transition in which A and B change together in the filtered pair gives no count and leaves `dir_state_o` unchanged.
- R10: While `cnt_en_i` is 0, no strobe is issued, but `dir_state_o` still tracks the decoded direction.
- R11: `step_o` is never high on two consecutive clocks, and `dir_up_o` gives the direction of the strobe that accompanies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_a_i | input | 1 | Raw encoder channel A (asynchronous) |
| chan_b_i | input | 1 | Raw encoder channel B (asynchronous) |
| mode_i | input | 2 | 00 clock/direction, 01 x1, 10 x2, 11 x4 |
| filt_div2_i | input | 1 | 1 halves the filter tick rate |
| cnt_en_i | input | 1 | Count enable; 0 suppresses strobes |
| step_o | output | 1 | One-cycle count strobe (valid, no ready) |
| dir_up_o | output | 1 | Direction of the current strobe, 1 = up |
| dir_state_o | output | 1 | Last decoded direction, 1 = up |

## Verification
The bench checks the resolution modes in both directions. A wrong edge choice in single resolution would either double the count or count only one direction. The bench sends an 8-clock pulse at each divide setting. A filter that ignored the divide select, or that accepted a change after one tick, would count that pulse at divide 2. It also steps A and B together. A design that treats this as a legal move would emit a strobe or flip the direction status. Finally, it runs a cycle with enable low. A design that gated direction tracking along with the strobe would leave a stale direction.

// File: rtl/qdf_pkg.sv
package qdf_pkg;

  typedef enum logic [1:0] {
    MODE_CLKDIR = 2'b00,
    MODE_X1     = 2'b01,
    MODE_X2     = 2'b10,
    MODE_X4     = 2'b11
  } qdf_mode_e;

  typedef struct packed {
    logic b;
    logic a;
  } qdf_pair_t;

endpackage

// File: rtl/qdf_tick_gen.sv
module qdf_tick_gen #(
  parameter int BASE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div2_i,
  output logic tick_o
);
  localparam int CW = $clog2(2 * BASE_DIV) + 1;
  localparam logic [CW-1:0] LIM1 = CW'(BASE_DIV - 1);
  localparam logic [CW-1:0] LIM2 = CW'(2 * BASE_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = div2_i ? LIM2 : LIM1;
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R8: the divider never runs past the longer of the two periods
  assert_tick_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM2);

  // R8: after a tick the divider restarts from zero
  assert_tick_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/qdf_in_filter.sv
module qdf_in_filter #(
  parameter int W           = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] filt_o
);
  logic [W-1:0] synced;
  logic [W-1:0] smp_q;
  logic [W-1:0] filt_q;

  for (genvar g = 0; g < W; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i[g]};
    end
    assign synced[g] = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q  <= '0;
      filt_q <= '0;
    end else if (tick_i) begin
      smp_q <= synced;
      if (synced == smp_q) filt_q <= synced;
    end
  end

  assign filt_o = filt_q;

  // R7: the filtered value moves only on a filter tick
  assert_filter_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> $past(tick_i));

  // R7: a filtered change equals the sample stored at the previous tick
  assert_filter_two_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(smp_q)));

endmodule

// File: rtl/qdf_edge_decode.sv
module qdf_edge_decode
  import qdf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] mode_i,
  input  qdf_pair_t cur_i,
  input  logic      cnt_en_i,
  output logic      step_o,
  output logic      dir_up_o,
  output logic      dir_state_o
);
  qdf_mode_e mode;
  qdf_pair_t prev_q;
  logic a_chg, b_chg, legal, q_up;
  logic evt, evt_up, upd, new_dir;
  logic step_q, dir_up_q, dir_state_q;

  assign mode  = qdf_mode_e'(mode_i);
  assign a_chg = cur_i.a ^ prev_q.a;
  assign b_chg = cur_i.b ^ prev_q.b;
  assign legal = a_chg ^ b_chg;
  // Up sequence {B,A}: 00 -> 01 -> 11 -> 10
  assign q_up  = a_chg ? (cur_i.a ^ prev_q.b) : ~(cur_i.b ^ prev_q.a);

  always_comb begin
    evt     = 1'b0;
    evt_up  = dir_state_q;
    upd     = 1'b0;
    new_dir = dir_state_q;
    unique case (mode)
      MODE_CLKDIR: begin
        if (a_chg && cur_i.a) begin
          evt     = 1'b1;
          evt_up  = cur_i.b;
          upd     = 1'b1;
          new_dir = cur_i.b;
        end
      end
      default: begin
        if (legal) begin
          upd     = 1'b1;
          new_dir = q_up;
          evt_up  = q_up;
          unique case (mode)
            MODE_X4: evt = 1'b1;
            MODE_X2: evt = a_chg;
            default: evt = a_chg && (cur_i.a == q_up);
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      step_q      <= 1'b0;
      dir_up_q    <= 1'b1;
      dir_state_q <= 1'b1;
    end else begin
      prev_q <= cur_i;
      step_q <= evt && cnt_en_i;
      if (evt) dir_up_q    <= evt_up;
      if (upd) dir_state_q <= new_dir;
    end
  end

  assign step_o      = step_q;
  assign dir_up_o    = dir_up_q;
  assign dir_state_o = dir_state_q;

  // R11: the strobe is a single clock wide
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    step_q |=> !step_q);

  // R10: enable low blocks the next strobe
  assert_enable_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en_i |=> !step_q);

  // R9: simultaneous change in a quadrature mode is silent
  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_CLKDIR && a_chg && b_chg) |=> (!step_q && $stable(dir_state_q)));

  // R4 / R5: B edges never count in x1 or x2
  assert_b_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_X2 || mode == MODE_X1) && b_chg && !a_chg) |=> !step_q);

  // R2: in clock/direction mode, a falling A edge does not count
  assert_clkdir_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLKDIR && a_chg && !cur_i.a) |=> !step_q);

endmodule

// File: rtl/qdec_front.sv
module qdec_front
  import qdf_pkg::*;
#(
  parameter int BASE_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_a_i,
  input  logic       chan_b_i,
  input  logic [1:0] mode_i,
  input  logic       filt_div2_i,
  input  logic       cnt_en_i,
  output logic       step_o,
  output logic       dir_up_o,
  output logic       dir_state_o
);
  localparam int NCH = $bits(qdf_pair_t);

  logic      tick;
  logic [NCH-1:0] filt;
  qdf_pair_t pair;

  qdf_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .div2_i (filt_div2_i),
    .tick_o (tick)
  );

  qdf_in_filter #(.W(NCH), .SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .raw_i  ({chan_b_i, chan_a_i}),
    .filt_o (filt)
  );

  assign pair = qdf_pair_t'(filt);

  qdf_edge_decode u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .cur_i       (pair),
    .cnt_en_i    (cnt_en_i),
    .step_o      (step_o),
    .dir_up_o    (dir_up_o),
    .dir_state_o (dir_state_o)
  );

  // R1: outputs hold their reset values in the first cycle after reset
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!step_o && dir_state_o && dir_up_o));

endmodule

// File: tb/qdec_front_tb_top.sv
`timescale 1ns/1ps
module qdec_front_tb_top;
  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_a = 1'b0, chan_b = 1'b0;
  logic [1:0] mode = 2'b11;
  logic div2 = 1'b0;
  logic cnt_en = 1'b1;
  logic step_o, dir_up_o, dir_state_o;

  always #2.5 clk = ~clk;

  qdec_front dut_i (
    .clk(clk), .rst_n(rst_n), .chan_a_i(chan_a), .chan_b_i(chan_b),
    .mode_i(mode), .filt_div2_i(div2), .cnt_en_i(cnt_en),
    .step_o(step_o), .dir_up_o(dir_up_o), .dir_state_o(dir_state_o)
  );

  int n_cmp = 0, n_bad = 0;
  int n_up = 0, n_dn = 0, n_dbl = 0;
  logic prev_step = 1'b0;
  int pos = 0;

  always @(negedge clk) begin
    if (step_o) begin
      if (dir_up_o) n_up++; else n_dn++;
      if (prev_step) n_dbl++;
    end
    prev_step = step_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic drive_pos();
    logic [1:0] g;
    g = 2'(pos ^ (pos >> 1));
    chan_a = g[0];
    chan_b = g[1];
  endtask

  task automatic quad_step(input logic up);
    pos = up ? (pos + 1) % 4 : (pos + 3) % 4;
    drive_pos();
    wait_hold();
  endtask

  task automatic settle();
    pos = 0;
    drive_pos();
    wait_hold();
    n_up = 0; n_dn = 0;
  endtask

  // {mode[1:0], div2, up, n[7:0], exp_up[7:0], exp_dn[7:0]}
  localparam int NV = 9;
  localparam logic [27:0] VEC [NV] = '{
    {2'b11, 1'b0, 1'b1, 8'd3, 8'd12, 8'd0},  // R3 R6
    {2'b11, 1'b1, 1'b0, 8'd2, 8'd0,  8'd8},  // R3 R6 R8
    {2'b10, 1'b0, 1'b1, 8'd3, 8'd6,  8'd0},  // R4
    {2'b10, 1'b0, 1'b0, 8'd2, 8'd0,  8'd4},  // R4
    {2'b01, 1'b0, 1'b1, 8'd5, 8'd5,  8'd0},  // R5
    {2'b01, 1'b1, 1'b0, 8'd3, 8'd0,  8'd3},  // R5
    {2'b00, 1'b0, 1'b1, 8'd4, 8'd4,  8'd0},  // R2
    {2'b00, 1'b0, 1'b0, 8'd2, 8'd0,  8'd2},  // R2
    {2'b11, 1'b1, 1'b1, 8'd1, 8'd4,  8'd0}   // R3
  };

  initial begin
    #(5ns * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 step_o in reset", int'(step_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 step_o", int'(step_o), 0);
    chk("R1 dir_state_o", int'(dir_state_o), 1);
    chk("R1 dir_up_o", int'(dir_up_o), 1);

    for (int v = 0; v < NV; v++) begin
      logic [27:0] e;
      e = VEC[v];
      settle();
      mode = e[27:26];
      div2 = e[25];
      wait_hold();
      n_up = 0; n_dn = 0;
      if (e[27:26] == 2'b00) begin
        chan_b = e[24];
        wait_hold();
        for (int k = 0; k < int'(e[23:16]); k++) begin
          chan_a = 1'b1; wait_hold();
          chan_a = 1'b0; wait_hold();
        end
      end else begin
        for (int k = 0; k < 4 * int'(e[23:16]); k++) quad_step(e[24]);
      end
      chk($sformatf("R2-R6 vec%0d up counts", v), n_up, int'(e[15:8]));
      chk($sformatf("R2-R6 vec%0d down counts", v), n_dn, int'(e[7:0]));
      chk($sformatf("R6 vec%0d dir_state", v), int'(dir_state_o), int'(e[24]));
      chan_b = 1'b0;
      wait_hold();
    end

    // R7: short glitch on A at divide 1 is discarded
    mode = 2'b11; div2 = 1'b0;
    settle();
    chan_a = 1'b1; repeat (3) @(negedge clk); chan_a = 1'b0;
    wait_hold();
    chk("R7 short glitch strobes", n_up + n_dn, 0);

    // R8: 8-clock pulse accepted at divide 1
    settle();
    chan_a = 1'b1; repeat (8) @(negedge clk); chan_a = 1'b0;
    wait_hold();
    chk("R8 div1 pulse up", n_up, 1);
    chk("R8 div1 pulse down", n_dn, 1);

    // R8: same pulse discarded at divide 2
    div2 = 1'b1;
    settle();
    chan_a = 1'b1; repeat (8) @(negedge clk); chan_a = 1'b0;
    wait_hold();
    chk("R8 div2 pulse strobes", n_up + n_dn, 0);

    // R9: simultaneous change of A and B
    div2 = 1'b0;
    settle();
    quad_step(1'b0);                  // 00 -> 10, down
    chk("R9 setup dir", int'(dir_state_o), 0);
    n_up = 0; n_dn = 0;
    chan_a = 1'b1; chan_b = 1'b0;     // 10 -> 01 together
    wait_hold();
    chk("R9 illegal strobes", n_up + n_dn, 0);
    chk("R9 illegal dir kept", int'(dir_state_o), 0);
    chan_a = 1'b0;
    wait_hold();

    // R10: enable low suppresses strobes but direction tracks
    settle();
    for (int k = 0; k < 4; k++) quad_step(1'b0);
    chk("R10 enabled down dir", int'(dir_state_o), 0);
    cnt_en = 1'b0;
    n_up = 0; n_dn = 0;
    for (int k = 0; k < 4; k++) quad_step(1'b1);
    chk("R10 disabled strobes", n_up + n_dn, 0);
    chk("R10 disabled dir tracks", int'(dir_state_o), 1);
    cnt_en = 1'b1;

    // R11: no strobe ever lasted two clocks
    chk("R11 back-to-back strobes", n_dbl, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule